// File: doc/BRIEF.md
# Autobaud Synchroniser with Identity Reply

This block watches a raw serial receive line before any UART exists on it. It waits for one synchronisation character, backspace (0x08, eight data bits, no parity), and derives the host's bit period in clock cycles from that character. Because 0x08 is sent LSB first, the start bit and the three low data bits form one low run of four bit-times. The block times that run and divides it by four, rounding to the nearest whole cycle. It then checks the rest of the character at the predicted mid-bit instants. Only when the stop bit is seen high at its predicted time does the block lock.

Once locked, the block holds the divisor and the locked flag until reset. It sends a 24-byte identification packet on its transmit line at the learned rate, with no further prompt. The first 22 bytes come from a parameter, in this order: a 15-byte product identifier, 3 version bytes and 4 reserved bytes. The block itself appends a line feed and then a carriage return. The accepted rate window is set by the parameters MIN_DIV and MAX_DIV in clocks per bit. These are chosen from the clock frequency to cover 600 bps to 115,200 bps.

Top module: `autobaud_ident`

## Requirements
- R1: While reset is held and right after its release, txd_o is 1, locked_o is 0 and divisor_o is 0.
- R2: A 0x08 character framed 8N1 with a bit period of D clocks, where MIN_DIV <= D <= MAX_DIV, sets locked_o to 1. divisor_o then equals D, which is the low run of four bit-times divided by four and rounded to the nearest cycle.
- R3: A low pulse on rx_i shorter than GLITCH_MIN clocks is ignored. It does not lock the block, and a following valid sync character locks at that character's own period.
- R4: The block does not lock, leaves divisor_o at 0 and keeps txd_o high in either of these cases: the derived period is below MIN_DIV or above MAX_DIV, or the low run exceeds 4*MAX_DIV+3 clocks. Once the line returns high, the block re-arms for a new sync character.
- R5: After the low run, the line is sampled at mid-bit instants and must read 1,0,0,0,0 (data bits 3 to 7 of 0x08) and then 1 (stop bit). Any mismatch means no lock. For example, 0x48 and 0x00 do not lock.
- R6: After lock, exactly 24 bytes leave on txd_o without any prompt. Each byte has a low start bit, eight data bits LSB first and a high stop bit, and each bit lasts divisor_o clocks. Bytes 0 to 21 are the bytes of ID_TEXT, taken from its most significant byte down (the first character of a string literal is sent first).
- R7: Byte 22 of the packet is 0x0A and byte 23 is 0x0D.
- R8: After lock, locked_o and divisor_o hold until reset. Further traffic on rx_i, including more 0x08 characters at another rate, has no effect, and txd_o stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_i | input | 1 | Raw serial receive line, idle high, asynchronous to clk |
| txd_o | output | 1 | Serial transmit line carrying the identity packet, idle high |
| locked_o | output | 1 | High once a valid sync character has been measured |
| divisor_o | output | $clog2(MAX_DIV+1) | Learned bit period in clocks, 0 until lock |

## Verification
The assertions assume three things about rx_i. It idles high before the first character. Each character it carries keeps a constant bit period. A new character does not begin while the previous one is still being checked at its predicted sample points. The stimulus meets these assumptions in three ways. It drives every bit as a whole number of clock cycles, changing rx_i only on falling clock edges. It leaves the line high for several bit-times after each rejected character. It starts the next frame only after the previous result is visible at the ports. Glitches are driven as isolated low pulses with the line high on both sides, so the measured low run equals the pulse width.

// File: rtl/abi_pkg.sv
package abi_pkg;
  localparam int unsigned ID_INFO_LEN  = 22;
  localparam int unsigned ID_TOTAL_LEN = 24;
  localparam logic [7:0]  SYNC_CHAR    = 8'h08;
  localparam logic [7:0]  TERM_LF      = 8'h0A;
  localparam logic [7:0]  TERM_CR      = 8'h0D;
  localparam int unsigned LOW_BITS     = 4;
  localparam int unsigned LAST_SLOT    = 5;

  typedef enum logic [2:0] {
    SY_ARM,
    SY_WAIT_FALL,
    SY_MEASURE,
    SY_CHECK,
    SY_LOCKED
  } sync_state_t;
endpackage

// File: rtl/abi_sync_det.sv
module abi_sync_det import abi_pkg::*; #(
  parameter int unsigned MIN_DIV    = 434,
  parameter int unsigned MAX_DIV    = 83333,
  parameter int unsigned GLITCH_MIN = 64,
  parameter int unsigned DIV_W      = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_s,
  output logic             locked_o,
  output logic [DIV_W-1:0] div_o
);
  localparam int unsigned LOW_LIMIT = LOW_BITS * MAX_DIV + 3;
  localparam int unsigned CNT_W     = $clog2(LOW_LIMIT + 1);

  sync_state_t      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] tmr_q, tmr_d;
  logic [2:0]       slot_q, slot_d;

  logic [CNT_W:0]   rnd;
  logic [CNT_W-1:0] cand;
  logic             cand_ok;
  logic [3:0]       bit_pos;
  logic             exp_bit;

  // rounded quarter of the low run
  assign rnd     = {1'b0, cnt_q} + (CNT_W+1)'(2);
  assign cand    = {1'b0, rnd[CNT_W:2]};
  assign cand_ok = (cand >= CNT_W'(MIN_DIV)) && (cand <= CNT_W'(MAX_DIV));

  // slots 0..4 are data bits 3..7 of the sync char, slot 5 is the stop bit
  assign bit_pos = {1'b0, slot_q} + 4'd3;
  assign exp_bit = (slot_q == 3'(LAST_SLOT)) ? 1'b1 : SYNC_CHAR[bit_pos[2:0]];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    div_d   = div_q;
    tmr_d   = tmr_q;
    slot_d  = slot_q;
    unique case (state_q)
      SY_ARM: begin
        if (rx_s) state_d = SY_WAIT_FALL;
      end
      SY_WAIT_FALL: begin
        if (!rx_s) begin
          state_d = SY_MEASURE;
          cnt_d   = CNT_W'(1);
        end
      end
      SY_MEASURE: begin
        if (!rx_s) begin
          if (cnt_q == CNT_W'(LOW_LIMIT)) state_d = SY_ARM;
          else                            cnt_d   = cnt_q + CNT_W'(1);
        end else if (cnt_q < CNT_W'(GLITCH_MIN)) begin
          state_d = SY_WAIT_FALL;
        end else if (cand_ok) begin
          state_d = SY_CHECK;
          div_d   = DIV_W'(cand);
          tmr_d   = DIV_W'(cand >> 1);
          slot_d  = 3'd0;
        end else begin
          state_d = SY_ARM;
        end
      end
      SY_CHECK: begin
        if (tmr_q == '0) begin
          if (rx_s != exp_bit)                 state_d = SY_ARM;
          else if (slot_q == 3'(LAST_SLOT))    state_d = SY_LOCKED;
          else begin
            slot_d = slot_q + 3'd1;
            tmr_d  = div_q - DIV_W'(1);
          end
        end else begin
          tmr_d = tmr_q - DIV_W'(1);
        end
      end
      SY_LOCKED: state_d = SY_LOCKED;
      default:   state_d = SY_ARM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SY_ARM;
      cnt_q   <= '0;
      div_q   <= '0;
      tmr_q   <= '0;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      div_q   <= div_d;
      tmr_q   <= tmr_d;
      slot_q  <= slot_d;
    end
  end

  logic lock_st;
  assign lock_st  = (state_q == SY_LOCKED);
  assign locked_o = lock_st;
  assign div_o    = lock_st ? div_q : '0;

  // R8
  hold_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_st |=> (lock_st && $stable(div_q)));

  // R4
  lock_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_st) |-> ((div_q >= DIV_W'(MIN_DIV)) && (div_q <= DIV_W'(MAX_DIV))));

  // R5
  stop_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_st) |-> ($past(state_q) == SY_CHECK && $past(rx_s)));
endmodule

// File: rtl/abi_tx8n1.sv
module abi_tx8n1 #(
  parameter int unsigned DIV_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             start_i,
  input  logic [7:0]       data_i,
  output logic             busy_o,
  output logic             txd_o
);
  localparam int unsigned FRAME_BITS = 10;

  logic             busy_q, busy_d;
  logic [9:0]       fr_q, fr_d;
  logic [DIV_W-1:0] tmr_q, tmr_d;
  logic [3:0]       nb_q, nb_d;
  logic             bit_end;

  assign bit_end = (tmr_q == div_i - DIV_W'(1));

  always_comb begin
    busy_d = busy_q;
    fr_d   = fr_q;
    tmr_d  = tmr_q;
    nb_d   = nb_q;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        fr_d   = {1'b1, data_i, 1'b0};
        tmr_d  = '0;
        nb_d   = '0;
      end
    end else if (bit_end) begin
      tmr_d = '0;
      if (nb_q == 4'(FRAME_BITS - 1)) begin
        busy_d = 1'b0;
      end else begin
        nb_d = nb_q + 4'd1;
        fr_d = {1'b1, fr_q[9:1]};
      end
    end else begin
      tmr_d = tmr_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fr_q   <= '1;
      tmr_q  <= '0;
      nb_q   <= '0;
    end else begin
      busy_q <= busy_d;
      fr_q   <= fr_d;
      tmr_q  <= tmr_d;
      nb_q   <= nb_d;
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = fr_q[0];

  // R6
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q);

  // R6
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd_o);
endmodule

// File: rtl/abi_id_seq.sv
module abi_id_seq import abi_pkg::*; #(
  parameter logic [8*ID_INFO_LEN-1:0] ID_TEXT = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic       busy_i,
  output logic       start_o,
  output logic [7:0] data_o
);
  logic [4:0] idx_q, idx_d;
  logic       start_q, start_d;
  logic [7:0] data_q, data_d;
  logic [7:0] byte_sel;
  logic       fire;

  always_comb begin
    if (idx_q < 5'(ID_INFO_LEN))
      byte_sel = ID_TEXT[8*(ID_INFO_LEN-1-int'(idx_q)) +: 8];
    else if (idx_q == 5'(ID_INFO_LEN))
      byte_sel = TERM_LF;
    else
      byte_sel = TERM_CR;
  end

  assign fire = go_i && (idx_q < 5'(ID_TOTAL_LEN)) && !busy_i && !start_q;

  always_comb begin
    idx_d   = idx_q;
    data_d  = data_q;
    start_d = fire;
    if (fire) begin
      idx_d  = idx_q + 5'd1;
      data_d = byte_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      start_q <= 1'b0;
      data_q  <= '0;
    end else begin
      idx_q   <= idx_d;
      start_q <= start_d;
      data_q  <= data_d;
    end
  end

  assign start_o = start_q;
  assign data_o  = data_q;

  // R6
  start_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> go_i);

  // R8
  packet_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == 5'(ID_TOTAL_LEN)) |=> ((idx_q == 5'(ID_TOTAL_LEN)) && !start_q));
endmodule

// File: rtl/autobaud_ident.sv
module autobaud_ident import abi_pkg::*; #(
  parameter int unsigned MIN_DIV    = 434,
  parameter int unsigned MAX_DIV    = 83333,
  parameter int unsigned GLITCH_MIN = 64,
  parameter logic [8*ID_INFO_LEN-1:0] ID_TEXT = "SERIALBOOT-COREB2R    ",
  localparam int unsigned DIV_W = $clog2(MAX_DIV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  output logic             txd_o,
  output logic             locked_o,
  output logic [DIV_W-1:0] divisor_o
);
  logic [1:0]       rst_q;
  logic             rst_sync_n;
  logic [1:0]       rx_q;
  logic             locked;
  logic [DIV_W-1:0] div;
  logic             tx_busy;
  logic             tx_start;
  logic [7:0]       tx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rx_q <= '1;
    else             rx_q <= {rx_q[0], rx_i};
  end

  abi_sync_det #(
    .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV),
    .GLITCH_MIN(GLITCH_MIN), .DIV_W(DIV_W)
  ) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .rx_s(rx_q[1]),
    .locked_o(locked), .div_o(div)
  );

  abi_id_seq #(.ID_TEXT(ID_TEXT)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .go_i(locked), .busy_i(tx_busy),
    .start_o(tx_start), .data_o(tx_data)
  );

  abi_tx8n1 #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_sync_n), .div_i(div), .start_i(tx_start),
    .data_i(tx_data), .busy_o(tx_busy), .txd_o(txd_o)
  );

  assign locked_o  = locked;
  assign divisor_o = div;
endmodule

// File: tb/sim_autobaud_ident.sv
`timescale 1ns/1ps
module sim_autobaud_ident;
  localparam int unsigned MIN_D = 8;
  localparam int unsigned MAX_D = 40;
  localparam int unsigned GLT   = 6;
  localparam logic [8*22-1:0] BENCH_ID = "TESTUNIT0123456V9Zabcd";
  localparam int unsigned DW = $clog2(MAX_D + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic rx;
  wire  txd;
  wire  locked;
  wire  [DW-1:0] div;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] got [24];
  int got_n;
  int frame_bad;

  always #2.5 clk = ~clk;

  autobaud_ident #(
    .MIN_DIV(MIN_D), .MAX_DIV(MAX_D), .GLITCH_MIN(GLT), .ID_TEXT(BENCH_ID)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .rx_i(rx),
    .txd_o(txd), .locked_o(locked), .divisor_o(div)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rx    = 1'b1;
    idle(4);
    rst_n = 1'b1;
    idle(4);
  endtask

  task automatic send_char(input logic [7:0] b, input int d);
    rx = 1'b0;
    idle(d);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      idle(d);
    end
    rx = 1'b1;
    idle(d);
  endtask

  task automatic pulse_low(input int n);
    rx = 1'b0;
    idle(n);
    rx = 1'b1;
  endtask

  task automatic quiet_watch(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
  endtask

  task automatic capture(input int d);
    got_n = 0;
    frame_bad = 0;
    for (int k = 0; k < 24; k++) begin
      int w = 0;
      logic [7:0] b;
      while (txd !== 1'b0 && w < 40*d + 100) begin
        @(negedge clk);
        w++;
      end
      if (txd !== 1'b0) return;
      idle(d/2);
      if (txd !== 1'b0) frame_bad++;
      for (int i = 0; i < 8; i++) begin
        idle(d);
        b[i] = txd;
      end
      idle(d);
      if (txd !== 1'b1) frame_bad++;
      got[k] = b;
      got_n++;
    end
  endtask

  task automatic verify_id();
    chk(got_n == 24, "R6", "bytes received", got_n, 24);
    chk(frame_bad == 0, "R6", "start/stop framing errors", frame_bad, 0);
    for (int k = 0; k < 22; k++) begin
      logic [7:0] e;
      e = BENCH_ID[8*(21-k) +: 8];
      chk(got[k] == e, "R6", $sformatf("id byte %0d", k), got[k], e);
    end
    chk(got[22] == 8'h0A, "R7", "byte 22 line feed", got[22], 8'h0A);
    chk(got[23] == 8'h0D, "R7", "byte 23 carriage return", got[23], 8'h0D);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    rx    = 1'b1;
    idle(3);
    chk(txd == 1'b1, "R1", "txd in reset", txd, 1);
    chk(locked == 1'b0, "R1", "locked in reset", locked, 0);
    chk(div == '0, "R1", "divisor in reset", div, 0);
    rst_n = 1'b1;
    idle(5);
    chk(txd == 1'b1 && locked == 1'b0 && div == '0, "R1",
        "outputs after release", {txd, locked}, 2);
  endtask

  task automatic t_lock(input int d);
    do_reset();
    fork
      send_char(8'h08, d);
      capture(d);
    join
    chk(locked == 1'b1, "R2", $sformatf("locked at period %0d", d), locked, 1);
    chk(int'(div) == d, "R2", "divisor value", div, d);
    verify_id();
  endtask

  task automatic t_range();
    int lows;
    do_reset();
    fork
      send_char(8'h08, MIN_D - 1);
      quiet_watch(12*(MIN_D - 1) + 30, lows);
    join
    chk(locked == 1'b0, "R4", "no lock below MIN_DIV", locked, 0);
    chk(div == '0, "R4", "divisor stays 0 below range", div, 0);
    chk(lows == 0, "R4", "txd quiet below range", lows, 0);
    fork
      send_char(8'h08, MAX_D + 1);
      quiet_watch(12*(MAX_D + 1) + 30, lows);
    join
    chk(locked == 1'b0, "R4", "no lock above MAX_DIV", locked, 0);
    chk(lows == 0, "R4", "txd quiet above range", lows, 0);
    fork
      send_char(8'h08, 9);
      capture(9);
    join
    chk(locked == 1'b1 && int'(div) == 9, "R4", "re-armed and locked at 9",
        div, 9);
  endtask

  task automatic t_glitch();
    do_reset();
    pulse_low(GLT - 3);
    idle(30);
    pulse_low(GLT - 1);
    idle(30);
    chk(locked == 1'b0, "R3", "short pulses do not lock", locked, 0);
    chk(txd == 1'b1, "R3", "txd idle after glitches", txd, 1);
    fork
      send_char(8'h08, 12);
      capture(12);
    join
    chk(locked == 1'b1, "R3", "lock after glitches", locked, 1);
    chk(int'(div) == 12, "R3", "divisor unaffected by glitches", div, 12);
  endtask

  task automatic t_pattern();
    int lows;
    do_reset();
    fork
      send_char(8'h48, 10);
      quiet_watch(140, lows);
    join
    idle(20);
    chk(locked == 1'b0, "R5", "0x48 rejected", locked, 0);
    fork
      send_char(8'h00, 10);
      quiet_watch(140, lows);
    join
    idle(60);
    chk(locked == 1'b0, "R5", "0x00 rejected", locked, 0);
    chk(lows == 0, "R5", "txd quiet after rejects", lows, 0);
    fork
      send_char(8'h08, 10);
      capture(10);
    join
    chk(locked == 1'b1 && int'(div) == 10, "R5", "sync after rejects", div, 10);
  endtask

  task automatic t_hold();
    int lows;
    do_reset();
    fork
      send_char(8'h08, 10);
      capture(10);
    join
    chk(got_n == 24, "R8", "first packet complete", got_n, 24);
    fork
      begin
        send_char(8'h08, 20);
        send_char(8'h55, 10);
        send_char(8'h08, 8);
      end
      quiet_watch(200 + 100 + 80 + 60, lows);
    join
    chk(locked == 1'b1, "R8", "locked held", locked, 1);
    chk(int'(div) == 10, "R8", "divisor held", div, 10);
    chk(lows == 0, "R8", "no second packet", lows, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    report();
    $finish;
  end

  initial begin
    t_reset();
    t_lock(10);
    t_lock(MIN_D);
    t_lock(MAX_D);
    t_range();
    t_glitch();
    t_pattern();
    t_hold();
    report();
    $finish;
  end
endmodule